// File: doc/BRIEF.md
# CRC-16 Memory Scan Accelerator

This block offloads a 16-bit cyclic redundancy check over a range of bytes in external memory. A processor programs a start pointer and a byte count through a small word-addressed register window on a Wishbone slave port. It then writes a start bit and polls a status word until the unit reports completion. It finally reads back the 16-bit result.

While a run is in progress the unit acts as a Wishbone master. It issues one 32-bit read per byte at the word-aligned address that holds the current byte, picks the addressed byte lane and folds that byte into the CRC register. It then advances the pointer by one. The CRC uses the polynomial 0x1021 with a zero initial value. Bits are processed most significant first, with no reflection and no final XOR.

Top module: `crc16_scan_accel`

## Requirements
- R1: After reset the status word reads 0 (not busy, not done), the result word reads 0, and no master bus cycle is active.
- R2: Every slave request (s_cyc and s_stb high) is acknowledged by a single-cycle s_ack pulse in the cycle after it is first seen. Reads return registered data with that acknowledge. Word 0 (start pointer) and word 1 (byte count) read back what was last written. Word 2 reads as 0, and any word from 5 to 15 reads as 0.
- R3: A write to word 2 with bit 0 set, while the unit is idle, starts a run. The run clears the done flag and the result to 0 and raises busy (status bit 0) from the next cycle whenever the count is not zero.
- R4: Each byte is XORed into bits 15:8 of the CRC register, followed by eight steps: shift left by one and XOR with 0x1021 when bit 15 was set before the shift. The nine bytes of the ASCII string "123456789" give 0x31C3.
- R5: While busy, m_cyc and m_stb stay high. m_adr is the current pointer with bits 1:0 forced to 0, and it is held until m_ack. The byte used is lane pointer[1:0] of m_dat_i, little-endian: lane 0 is bits 7:0 and lane 3 is bits 31:24.
- R6: A run performs exactly as many acknowledged memory reads as the programmed count. The pointer advances by one byte after each read.
- R7: In the cycle after the last acknowledged read, busy is 0 and done (status bit 1) is 1. Word 4 bits 15:0 then hold the CRC, and bits 31:16 read 0.
- R8: A start with a count of 0 sets done with busy 0 in the next cycle. It issues no memory read and leaves the result at 0x0000.
- R9: A start write while busy is ignored, including one accepted in the same cycle as the final memory acknowledge. The running transfer and its result are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_cyc | input | 1 | Slave bus cycle |
| s_stb | input | 1 | Slave strobe |
| s_we | input | 1 | Slave write enable |
| s_adr | input | 4 | Slave word address |
| s_dat_i | input | 32 | Slave write data |
| s_dat_o | output | 32 | Slave read data |
| s_ack | output | 1 | Slave acknowledge |
| m_cyc | output | 1 | Master bus cycle |
| m_stb | output | 1 | Master strobe |
| m_adr | output | 32 | Master byte address, word aligned |
| m_dat_i | input | 32 | Master read data |
| m_ack | input | 1 | Master acknowledge |

## Verification
Two events can meet on one clock edge: the slave port accepting a start write, and the fetch engine taking the final memory acknowledge of a run. A correct unit must still see itself as busy on that edge and drop the new start. A status read accepted on that same edge must also still report busy. The bench provokes this by issuing a second start at a sweep of cycle offsets from the first, with zero memory latency, so that one offset lands exactly on the last acknowledge. A behavioural model that applies the acknowledge before the start judges every cycle of the sweep, comparing bus activity, acknowledges and read data.

// File: rtl/crc16_scan_pkg.sv
package crc16_scan_pkg;

  localparam logic [15:0] CRC_POLY = 16'h1021;

  // word indices on the control port
  localparam int unsigned IDX_PTR  = 0;
  localparam int unsigned IDX_CNT  = 1;
  localparam int unsigned IDX_CTRL = 2;
  localparam int unsigned IDX_STAT = 3;
  localparam int unsigned IDX_RES  = 4;

  // one byte folded into the running CRC, MSB first
  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {b, 8'h00};
    for (int k = 0; k < 8; k++) begin
      if (r[15]) r = (r << 1) ^ CRC_POLY;
      else       r = r << 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/crc16_scan_regs.sv
module crc16_scan_regs
  import crc16_scan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int RADR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_cyc,
  input  logic              s_stb,
  input  logic              s_we,
  input  logic [RADR_W-1:0] s_adr,
  input  logic [DATA_W-1:0] s_dat_i,
  output logic [DATA_W-1:0] s_dat_o,
  output logic              s_ack,
  input  logic              eng_busy,
  input  logic              eng_done,
  input  logic [15:0]       eng_crc,
  output logic [ADDR_W-1:0] cfg_ptr,
  output logic [CNT_W-1:0]  cfg_cnt,
  output logic              start_evt
);

  logic              acc;
  logic              wr;
  logic [DATA_W-1:0] rd_word;

  assign acc       = s_cyc & s_stb & ~s_ack;
  assign wr        = acc & s_we;
  assign start_evt = wr & (s_adr == RADR_W'(IDX_CTRL)) & s_dat_i[0] & ~eng_busy;

  always_comb begin
    rd_word = '0;
    case (s_adr)
      RADR_W'(IDX_PTR):  rd_word[ADDR_W-1:0] = cfg_ptr;
      RADR_W'(IDX_CNT):  rd_word[CNT_W-1:0]  = cfg_cnt;
      RADR_W'(IDX_STAT): rd_word[1:0]        = {eng_done, eng_busy};
      RADR_W'(IDX_RES):  rd_word[15:0]       = eng_crc;
      default:           rd_word             = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_ack   <= 1'b0;
      s_dat_o <= '0;
      cfg_ptr <= '0;
      cfg_cnt <= '0;
    end else begin
      s_ack <= acc;
      if (acc && !s_we) s_dat_o <= rd_word;
      if (wr && s_adr == RADR_W'(IDX_PTR)) cfg_ptr <= s_dat_i[ADDR_W-1:0];
      if (wr && s_adr == RADR_W'(IDX_CNT)) cfg_cnt <= s_dat_i[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/crc16_scan_engine.sv
module crc16_scan_engine
  import crc16_scan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic [ADDR_W-1:0] cfg_ptr,
  input  logic [CNT_W-1:0]  cfg_cnt,
  output logic              m_cyc,
  output logic              m_stb,
  output logic [ADDR_W-1:0] m_adr,
  input  logic [DATA_W-1:0] m_dat_i,
  input  logic              m_ack,
  output logic              busy,
  output logic              done,
  output logic [15:0]       crc,
  output logic              last_evt
);

  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);

  logic [ADDR_W-1:0] cur;
  logic [CNT_W-1:0]  rem;
  logic [7:0]        lane;
  logic              beat;

  always_comb begin
    lane = '0;
    for (int i = 0; i < LANES; i++)
      if (cur[LANE_W-1:0] == LANE_W'(i)) lane = m_dat_i[i*8 +: 8];
  end

  assign beat     = busy & m_ack;
  assign last_evt = beat & (rem == CNT_W'(1));
  assign m_cyc    = busy;
  assign m_stb    = busy;
  assign m_adr    = {cur[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      crc  <= '0;
      cur  <= '0;
      rem  <= '0;
    end else if (start_evt && !busy) begin
      crc  <= '0;
      cur  <= cfg_ptr;
      rem  <= cfg_cnt;
      busy <= (cfg_cnt != '0);
      done <= (cfg_cnt == '0);
    end else if (beat) begin
      crc <= crc16_byte(crc, lane);
      cur <= cur + ADDR_W'(1);
      rem <= rem - CNT_W'(1);
      if (last_evt) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/crc16_scan_accel.sv
module crc16_scan_accel
  import crc16_scan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int RADR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_cyc,
  input  logic              s_stb,
  input  logic              s_we,
  input  logic [RADR_W-1:0] s_adr,
  input  logic [DATA_W-1:0] s_dat_i,
  output logic [DATA_W-1:0] s_dat_o,
  output logic              s_ack,
  output logic              m_cyc,
  output logic              m_stb,
  output logic [ADDR_W-1:0] m_adr,
  input  logic [DATA_W-1:0] m_dat_i,
  input  logic              m_ack
);

  localparam int LANE_W = $clog2(DATA_W / 8);

  logic              busy;
  logic              done;
  logic [15:0]       crc;
  logic              start_evt;
  logic              last_evt;
  logic [ADDR_W-1:0] cfg_ptr;
  logic [CNT_W-1:0]  cfg_cnt;
  logic              cnt_zero;

  assign cnt_zero = (cfg_cnt == '0);

  crc16_scan_regs #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .RADR_W(RADR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .s_cyc(s_cyc), .s_stb(s_stb), .s_we(s_we), .s_adr(s_adr),
    .s_dat_i(s_dat_i), .s_dat_o(s_dat_o), .s_ack(s_ack),
    .eng_busy(busy), .eng_done(done), .eng_crc(crc),
    .cfg_ptr(cfg_ptr), .cfg_cnt(cfg_cnt), .start_evt(start_evt)
  );

  crc16_scan_engine #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
  ) u_engine (
    .clk(clk), .rst_n(rst_n),
    .start_evt(start_evt), .cfg_ptr(cfg_ptr), .cfg_cnt(cfg_cnt),
    .m_cyc(m_cyc), .m_stb(m_stb), .m_adr(m_adr), .m_dat_i(m_dat_i), .m_ack(m_ack),
    .busy(busy), .done(done), .crc(crc), .last_evt(last_evt)
  );

endmodule

// File: rtl/crc16_scan_accel_chk.sv
module crc16_scan_accel_chk #(
  parameter int ADDR_W = 32,
  parameter int LANE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_ack,
  input logic              m_stb,
  input logic [ADDR_W-1:0] m_adr,
  input logic              m_ack,
  input logic              m_cyc,
  input logic              busy,
  input logic              done,
  input logic              start_evt,
  input logic              last_evt,
  input logic              cnt_zero
);

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    s_ack |=> !s_ack); // R2

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_evt)); // R3

  AST_ADR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    m_stb |-> (m_adr[LANE_W-1:0] == '0)); // R5

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_stb && !m_ack) |=> (m_stb && $stable(m_adr))); // R5

  AST_LAST_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    last_evt |=> (done && !busy)); // R7

  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && cnt_zero) |=> (done && !m_cyc)); // R8

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_evt) |=> busy); // R9

endmodule

bind crc16_scan_accel crc16_scan_accel_chk #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_ack(s_ack), .m_stb(m_stb), .m_adr(m_adr),
  .m_ack(m_ack), .m_cyc(m_cyc), .busy(busy), .done(done),
  .start_evt(start_evt), .last_evt(last_evt), .cnt_zero(cnt_zero)
);

// File: tb/crc16_scan_accel_bench.sv
module crc16_scan_accel_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_cyc = 1'b0, s_stb = 1'b0, s_we = 1'b0;
  logic [3:0]  s_adr = '0;
  logic [31:0] s_dat_i = '0;
  logic [31:0] s_dat_o;
  logic        s_ack;
  logic        m_cyc, m_stb;
  logic [31:0] m_adr;
  logic [31:0] m_dat_i = '0;
  logic        m_ack = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  crc16_scan_accel u_crc16_scan_accel (
    .clk(clk), .rst_n(rst_n),
    .s_cyc(s_cyc), .s_stb(s_stb), .s_we(s_we), .s_adr(s_adr),
    .s_dat_i(s_dat_i), .s_dat_o(s_dat_o), .s_ack(s_ack),
    .m_cyc(m_cyc), .m_stb(m_stb), .m_adr(m_adr), .m_dat_i(m_dat_i), .m_ack(m_ack)
  );

  int total = 0;
  int fails = 0;
  int cycles = 0;
  int lat = 0;
  int wait_cnt = 0;
  logic [7:0] mem [0:255];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // bitwise CRC written as per-bit feedback
  function automatic logic [15:0] ref_step(input logic [15:0] c, input logic [7:0] b);
    logic fb;
    for (int i = 7; i >= 0; i--) begin
      fb = c[15] ^ b[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  function automatic logic [15:0] ref_crc(input int base, input int len);
    logic [15:0] c = 16'h0000;
    for (int i = 0; i < len; i++) c = ref_step(c, mem[(base + i) & 255]);
    return c;
  endfunction

  // ---------------- behavioural reference model ----------------
  bit          mdl_busy, mdl_done, mdl_sack, mdl_rd_pend;
  logic [15:0] mdl_crc;
  logic [31:0] mdl_ptr, mdl_cnt, mdl_cur, mdl_rem, mdl_rdata;
  int          beats;

  always @(posedge clk) begin
    bit was_busy, acc;
    if (!rst_n) begin
      mdl_busy = 0; mdl_done = 0; mdl_sack = 0; mdl_rd_pend = 0;
      mdl_crc = 0; mdl_ptr = 0; mdl_cnt = 0; mdl_cur = 0; mdl_rem = 0;
      mdl_rdata = 0; beats = 0;
    end else begin
      was_busy = mdl_busy;
      acc = s_cyc && s_stb && !mdl_sack;
      if (acc && !s_we) begin
        case (s_adr)
          4'd0: mdl_rdata = mdl_ptr;
          4'd1: mdl_rdata = mdl_cnt;
          4'd3: mdl_rdata = {30'd0, mdl_done, mdl_busy};
          4'd4: mdl_rdata = {16'd0, mdl_crc};
          default: mdl_rdata = 32'd0;
        endcase
      end
      mdl_rd_pend = acc && !s_we;
      if (was_busy && m_ack) begin
        mdl_crc = ref_step(mdl_crc, mem[mdl_cur[7:0]]);
        mdl_cur = mdl_cur + 1;
        mdl_rem = mdl_rem - 1;
        beats++;
        if (mdl_rem == 0) begin mdl_busy = 0; mdl_done = 1; end
      end
      if (acc && s_we) begin
        case (s_adr)
          4'd0: mdl_ptr = s_dat_i;
          4'd1: mdl_cnt = s_dat_i;
          4'd2: if (s_dat_i[0] && !was_busy) begin
                  mdl_crc = 0; mdl_cur = mdl_ptr; mdl_rem = mdl_cnt;
                  mdl_busy = (mdl_cnt != 0); mdl_done = (mdl_cnt == 0);
                end
          default: ;
        endcase
      end
      mdl_sack = acc;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(m_cyc === mdl_busy && m_stb === mdl_busy, "R5 bus activity", {31'd0, m_cyc}, {31'd0, mdl_busy});
      chk(s_ack === mdl_sack, "R2 ack timing", {31'd0, s_ack}, {31'd0, mdl_sack});
      if (mdl_busy) chk(m_adr === {mdl_cur[31:2], 2'b00}, "R6 address", m_adr, {mdl_cur[31:2], 2'b00});
      if (mdl_rd_pend) chk(s_dat_o === mdl_rdata, "R7 read data", s_dat_o, mdl_rdata);
    end
  end

  // memory responder
  always @(negedge clk) begin
    if (m_ack) begin
      m_ack <= 1'b0; wait_cnt <= 0;
    end else if (m_stb) begin
      if (wait_cnt >= lat) begin
        m_ack   <= 1'b1;
        m_dat_i <= {mem[{m_adr[7:2], 2'b11}], mem[{m_adr[7:2], 2'b10}],
                    mem[{m_adr[7:2], 2'b01}], mem[{m_adr[7:2], 2'b00}]};
      end else wait_cnt <= wait_cnt + 1;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic wb_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    s_cyc = 1; s_stb = 1; s_we = 1; s_adr = a; s_dat_i = d;
    do @(negedge clk); while (!s_ack);
    s_cyc = 0; s_stb = 0; s_we = 0;
  endtask

  task automatic wb_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    s_cyc = 1; s_stb = 1; s_we = 0; s_adr = a;
    do @(negedge clk); while (!s_ack);
    d = s_dat_o;
    s_cyc = 0; s_stb = 0;
  endtask

  task automatic wait_done();
    logic [31:0] st;
    int n = 0;
    do begin wb_read(4'd3, st); n++; end while (!st[1] && n < 2000);
  endtask

  task automatic run(input int p, input int c);
    wb_write(4'd0, p);
    wb_write(4'd1, c);
    wb_write(4'd2, 32'd1);
    wait_done();
  endtask

  initial begin
    logic [31:0] rd;
    int b0;
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) & 255);
    for (int i = 0; i < 9; i++) mem[5 + i] = 8'(8'h31 + i);

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    wb_read(4'd3, rd); chk(rd == 0, "R1 status", rd, 0);
    wb_read(4'd4, rd); chk(rd == 0, "R1 result", rd, 0);
    chk(m_cyc == 0, "R1 bus idle", {31'd0, m_cyc}, 0);

    // R2 register file
    wb_write(4'd0, 32'd5);  wb_read(4'd0, rd); chk(rd == 5, "R2 pointer", rd, 5);
    wb_write(4'd1, 32'd9);  wb_read(4'd1, rd); chk(rd == 9, "R2 count", rd, 9);
    wb_read(4'd2, rd); chk(rd == 0, "R2 control reads 0", rd, 0);
    wb_read(4'd9, rd); chk(rd == 0, "R2 unused word", rd, 0);

    // R4 known vector at an unaligned start, R6 beat count
    lat = 0; b0 = beats;
    run(5, 9);
    wb_read(4'd4, rd); chk(rd == 32'h31C3, "R4 check value", rd, 32'h31C3);
    chk(beats - b0 == 9, "R6 read count", beats - b0, 9);
    wb_read(4'd3, rd); chk(rd == 2, "R7 done status", rd, 2);

    // R5 lanes with memory wait states
    lat = 2;
    run(6, 7);
    wb_read(4'd4, rd); chk(rd == {16'd0, ref_crc(6, 7)}, "R5 lane select", rd, {16'd0, ref_crc(6, 7)});

    // R8 zero count
    b0 = beats;
    run(70, 0);
    wb_read(4'd4, rd); chk(rd == 0, "R8 zero result", rd, 0);
    chk(beats == b0, "R8 no reads", beats - b0, 0);

    // R3 start clears done; R9 second start while busy
    lat = 1; b0 = beats;
    wb_write(4'd0, 32'd40); wb_write(4'd1, 32'd20); wb_write(4'd2, 32'd1);
    wb_read(4'd3, rd); chk(rd == 1, "R3 busy, done cleared", rd, 1);
    wb_write(4'd0, 32'd100);
    wb_write(4'd2, 32'd1);
    wait_done();
    wb_read(4'd4, rd); chk(rd == {16'd0, ref_crc(40, 20)}, "R9 busy start ignored", rd, {16'd0, ref_crc(40, 20)});
    chk(beats - b0 == 20, "R9 read count", beats - b0, 20);

    // R9 start at a sweep of offsets, one meeting the final acknowledge
    lat = 0;
    wb_write(4'd0, 32'd60); wb_write(4'd1, 32'd2);
    for (int off = 0; off < 8; off++) begin
      wb_write(4'd2, 32'd1);
      repeat (off) @(negedge clk);
      wb_write(4'd2, 32'd1);
      wait_done();
      wb_read(4'd4, rd); chk(rd == {16'd0, ref_crc(60, 2)}, "R9 collision sweep", rd, {16'd0, ref_crc(60, 2)});
    end

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule